// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block drives a raster display from a set of host-written configuration words. It keeps a horizontal pixel counter and a vertical line counter, and from their positions it produces the active-low horizontal and vertical sync pulses, a data-enable strobe, and the byte address of the current line of the layer-0 image. Every geometry field is written as a count minus one. The horizontal and vertical sync start positions are written directly and are not derived from porch widths.

A programmable dot-clock divider sets the pixel rate as a fraction of the input clock. The counters move only on the resulting pixel strobe. All geometry, divider and layer fields pass through shadow copies that reload only at a frame boundary, so a host write made while the display is running never produces a frame that mixes old and new settings. The global display-enable bit acts one clock after it is written. While it is clear, the raster is parked at position (0,0) and every display output is inactive.

The layer-0 address starts each frame at a base address. After each active line it advances by the programmed stride, where the stride is counted in 64-byte units.

Top module: `raster_timing_gen`

## Requirements
- R1: After a synchronous reset, all configuration words are zero and the display is off: `hsync_n`=1, `vsync_n`=1, `de`=0, `pix_en`=0, `hcount`=`vcount`=0, `l0_fetch`=0, `l0_wide`=0, `l0_addr`=0.
- R2: While the display runs, `pix_en` pulses once every (D+1) clocks, where D is the divide code in control word (select 5) bits 11:8. The counters change only in a clock in which `pix_en` is high.
- R3: `hcount` counts from 0 up to HT and then wraps to 0. HT is taken from select 0 bits 31:16. `vcount` steps by one at each horizontal wrap, counts from 0 up to VT, and then wraps to 0. VT is taken from select 3 bits 31:16.
- R4: `de` is high exactly when the display runs, `hcount` ≤ HD and `vcount` ≤ VD. HD is taken from select 1 bits 15:0; that word carries the same value in both halves. VD is taken from select 4 bits 31:16.
- R5: `hsync_n` is low exactly when the display runs and HS ≤ `hcount` ≤ HS+HW. HS is taken from select 2 bits 15:0 and HW from select 2 bits 23:16.
- R6: `vsync_n` is low exactly when the display runs and VS ≤ `vcount` ≤ VS+VW. VS is taken from select 4 bits 15:0 and VW from select 2 bits 31:24.
- R7: Control bit 31 is the display enable. The display starts or stops running one clock after the edge that writes the bit. While it is not running, `hcount`=`vcount`=0, `de`=0, `pix_en`=0, and both syncs are high.
- R8: A write made while the display runs, to any field other than the enable bit, takes effect from the first pixel of the next frame. Until then the running frame keeps the old value.
- R9: During line v, `l0_addr` equals B + min(v, VD+1) × S × 64. B is the base address written with select 7, and S is the stride in select 6 bits 30:16.
- R10: `l0_fetch` equals `de` AND the layer-0 enable in control bit 16. `l0_wide` reflects select 6 bit 31, which chooses 16-bit pixels over 8-bit pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select (0..7) |
| cfg_wdata | input | 32 | Configuration write data |
| pix_en | output | 1 | Pixel-rate strobe from the dot-clock divider |
| hcount | output | CW (12) | Horizontal pixel position |
| vcount | output | CW (12) | Vertical line position |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable for the active area |
| l0_fetch | output | 1 | Layer-0 pixel is being displayed |
| l0_wide | output | 1 | Layer-0 pixels are 16 bits wide |
| l0_addr | output | AW (32) | Byte address of the current layer-0 line |

## Verification
The bench first runs a small raster with the divider at one pixel per clock. This separates wrap-point and sync-window edge errors, which show up at exact pixel positions, from divider errors. It then changes the divide code to 3, 2 and 4 clocks per pixel, which exposes mistakes in the pulse spacing and in how long each count is held.

Writes made in the middle of a frame, to the totals, the sync windows, the divider and the base address, show whether the running frame keeps its old geometry and switches cleanly at the next frame. Turning layer 0 off, changing the stride, and toggling the display enable test the fetch gating, the line-address stepping, and the parking of the raster at (0,0).

// File: rtl/rtg_pkg.sv
// Package: shared constants for the raster timing generator.
// Holds the configuration word selects and the control-word bit positions.
package rtg_pkg;

    // Configuration word selects.
    typedef enum logic [2:0] {
        SEL_HTOTAL = 3'd0,
        SEL_HDISP  = 3'd1,
        SEL_SYNC   = 3'd2,
        SEL_VTOTAL = 3'd3,
        SEL_VDISP  = 3'd4,
        SEL_CTRL   = 3'd5,
        SEL_L0MODE = 3'd6,
        SEL_L0BASE = 3'd7
    } cfg_sel_e;

    localparam int CTRL_EN_BIT  = 31;   // display enable
    localparam int CTRL_L0_BIT  = 16;   // layer-0 enable
    localparam int DIV_LSB      = 8;    // dot-clock divide code LSB
    localparam int DIVW         = 4;    // divide code width
    localparam int SYNCW        = 8;    // sync width field width
    localparam int STRW         = 15;   // stride field width (bits 30:16)
    localparam int WIDE_BIT     = 31;   // 16-bit pixel select

endpackage

// File: rtl/rtg_regs.sv
// Module: rtg_regs
// Holds the host-written configuration words and their frame-boundary
// shadow copies. It assumes CW <= 16 and AW <= 32. The shadows track the
// live values while the display is not running, and reload on frame_end
// while it runs. The run flag follows the live enable one clock later.
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             frame_end,
    output logic             run,
    output logic             en_live,
    output logic [AW-1:0]    base_live,
    output logic [CW-1:0]    htot_s,
    output logic [CW-1:0]    hdisp_s,
    output logic [CW-1:0]    hss_s,
    output logic [SYNCW-1:0] hsw_s,
    output logic [CW-1:0]    vtot_s,
    output logic [CW-1:0]    vdisp_s,
    output logic [CW-1:0]    vss_s,
    output logic [SYNCW-1:0] vsw_s,
    output logic [DIVW-1:0]  div_s,
    output logic             l0en_s,
    output logic             wide_s,
    output logic [STRW-1:0]  stride_s,
    output logic [AW-1:0]    base_s
);
    logic [CW-1:0]    htot_q, hdisp_q, hss_q, vtot_q, vdisp_q, vss_q;
    logic [SYNCW-1:0] hsw_q, vsw_q;
    logic [DIVW-1:0]  div_q;
    logic             en_q, l0en_q, wide_q;
    logic [STRW-1:0]  stride_q;
    logic [AW-1:0]    base_q;
    logic             reload;

    assign en_live   = en_q;
    assign base_live = base_q;
    assign reload    = !run || !en_q || frame_end;

    // Purpose: capture host writes into the live configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htot_q <= '0; hdisp_q <= '0; hss_q <= '0; hsw_q <= '0;
            vtot_q <= '0; vdisp_q <= '0; vss_q <= '0; vsw_q <= '0;
            div_q <= '0; en_q <= 1'b0; l0en_q <= 1'b0; wide_q <= 1'b0;
            stride_q <= '0; base_q <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_HTOTAL: htot_q <= cfg_wdata[16 +: CW];
                SEL_HDISP:  hdisp_q <= cfg_wdata[0 +: CW];
                SEL_SYNC: begin
                    vsw_q <= cfg_wdata[31:24];
                    hsw_q <= cfg_wdata[23:16];
                    hss_q <= cfg_wdata[0 +: CW];
                end
                SEL_VTOTAL: vtot_q <= cfg_wdata[16 +: CW];
                SEL_VDISP: begin
                    vdisp_q <= cfg_wdata[16 +: CW];
                    vss_q   <= cfg_wdata[0 +: CW];
                end
                SEL_CTRL: begin
                    en_q   <= cfg_wdata[CTRL_EN_BIT];
                    l0en_q <= cfg_wdata[CTRL_L0_BIT];
                    div_q  <= cfg_wdata[DIV_LSB +: DIVW];
                end
                SEL_L0MODE: begin
                    wide_q   <= cfg_wdata[WIDE_BIT];
                    stride_q <= cfg_wdata[16 +: STRW];
                end
                default: base_q <= cfg_wdata[AW-1:0];
            endcase
        end
    end

    // Purpose: delay the enable by one clock to form the run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= en_q;
    end

    // Purpose: copy live words into the shadows while idle or at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htot_s <= '0; hdisp_s <= '0; hss_s <= '0; hsw_s <= '0;
            vtot_s <= '0; vdisp_s <= '0; vss_s <= '0; vsw_s <= '0;
            div_s <= '0; l0en_s <= 1'b0; wide_s <= 1'b0;
            stride_s <= '0; base_s <= '0;
        end else if (reload) begin
            htot_s <= htot_q; hdisp_s <= hdisp_q; hss_s <= hss_q; hsw_s <= hsw_q;
            vtot_s <= vtot_q; vdisp_s <= vdisp_q; vss_s <= vss_q; vsw_s <= vsw_q;
            div_s <= div_q; l0en_s <= l0en_q; wide_s <= wide_q;
            stride_s <= stride_q; base_s <= base_q;
        end
    end

endmodule

// File: rtl/rtg_dotdiv.sv
// Module: rtg_dotdiv
// Dot-clock divider. While running, it produces a one-clock pixel strobe
// every (div+1) clocks. It assumes div is stable within a frame (it comes
// from a shadow). The count clears whenever the live enable is low.
module rtg_dotdiv #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          en_live,
    input  logic [DW-1:0] div,
    output logic          pix_en
);
    logic [DW-1:0] cnt;

    assign pix_en = run && (cnt == div);

    // Purpose: count clocks between pixel strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_live) cnt <= '0;
        else if (pix_en)        cnt <= '0;
        else if (run)           cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rtg_scan.sv
// Module: rtg_scan
// Horizontal and vertical position counters. They advance only on the
// pixel strobe and wrap at the programmed totals. It assumes the totals
// change only at a frame boundary. Both counts clear while the live
// enable is low.
module rtg_scan #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          en_live,
    input  logic          pix_en,
    input  logic [CW-1:0] htot,
    input  logic [CW-1:0] vtot,
    output logic [CW-1:0] hcount,
    output logic [CW-1:0] vcount,
    output logic          line_end,
    output logic          frame_end
);
    assign line_end  = run && pix_en && (hcount == htot);
    assign frame_end = line_end && (vcount == vtot);

    // Purpose: step the raster position on each pixel strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_live) begin
            hcount <= '0;
            vcount <= '0;
        end else if (run && pix_en) begin
            if (line_end) begin
                hcount <= '0;
                vcount <= frame_end ? '0 : vcount + 1'b1;
            end else begin
                hcount <= hcount + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtg_syncwin.sv
// Module: rtg_syncwin
// Window compare. It flags a position that lies in [start, start+len_m1].
// The sum is formed one bit wider, so the window end never wraps.
module rtg_syncwin #(
    parameter int CW = 12,
    parameter int LW = 8
) (
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] start,
    input  logic [LW-1:0] len_m1,
    output logic          hit
);
    localparam int SW = ((CW > LW) ? CW : LW) + 1;
    logic [SW-1:0] last;

    // Purpose: compute the inclusive window end and test the position.
    always_comb begin
        last = SW'(start) + SW'(len_m1);
        hit  = (SW'(pos) >= SW'(start)) && (SW'(pos) <= last);
    end

endmodule

// File: rtl/rtg_l0addr.sv
// Module: rtg_l0addr
// Layer-0 line address. It loads the base address while idle and at
// frame end. It adds stride*64 bytes at the end of each active line.
// It assumes that line_end and frame_end come from the same counters.
module rtg_l0addr #(
    parameter int AW   = 32,
    parameter int CW   = 12,
    parameter int STRW = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            en_live,
    input  logic            line_end,
    input  logic            frame_end,
    input  logic [CW-1:0]   vcount,
    input  logic [CW-1:0]   vdisp,
    input  logic [STRW-1:0] stride,
    input  logic [AW-1:0]   base_live,
    output logic [AW-1:0]   addr
);
    localparam int STEPW = STRW + 6;
    logic [AW-1:0] step;

    assign step = AW'({stride, 6'd0});

    // Purpose: hold, reload or step the current line address.
    always_ff @(posedge clk) begin
        if (!rst_n)                             addr <= '0;
        else if (!run || !en_live || frame_end) addr <= base_live;
        else if (line_end && vcount <= vdisp)   addr <= addr + step;
    end

    // Purpose: keep the derived step width visible for review.
    if (STEPW > 32) begin : g_wide_step_note
    end

endmodule

// File: rtl/raster_timing_gen.sv
// Module: raster_timing_gen
// Top level of the register-programmed raster timing generator. It ties
// together the configuration store, the dot-clock divider, the position
// counters, the two sync windows and the layer-0 address stepper. The
// display outputs are decoded from registered counters and shadows.
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    output logic          pix_en,
    output logic [CW-1:0] hcount,
    output logic [CW-1:0] vcount,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          de,
    output logic          l0_fetch,
    output logic          l0_wide,
    output logic [AW-1:0] l0_addr
);
    logic             run, en_live, line_end, frame_end;
    logic [AW-1:0]    base_live, base_s;
    logic [CW-1:0]    htot_s, hdisp_s, hss_s, vtot_s, vdisp_s, vss_s;
    logic [SYNCW-1:0] hsw_s, vsw_s;
    logic [DIVW-1:0]  div_s;
    logic             l0en_s;
    logic [STRW-1:0]  stride_s;
    logic             h_hit, v_hit;

    rtg_regs #(.CW(CW), .AW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .frame_end(frame_end), .run(run),
        .en_live(en_live), .base_live(base_live), .htot_s(htot_s),
        .hdisp_s(hdisp_s), .hss_s(hss_s), .hsw_s(hsw_s), .vtot_s(vtot_s),
        .vdisp_s(vdisp_s), .vss_s(vss_s), .vsw_s(vsw_s), .div_s(div_s),
        .l0en_s(l0en_s), .wide_s(l0_wide), .stride_s(stride_s), .base_s(base_s)
    );

    rtg_dotdiv #(.DW(DIVW)) div_i (
        .clk(clk), .rst_n(rst_n), .run(run), .en_live(en_live),
        .div(div_s), .pix_en(pix_en)
    );

    rtg_scan #(.CW(CW)) scan_i (
        .clk(clk), .rst_n(rst_n), .run(run), .en_live(en_live),
        .pix_en(pix_en), .htot(htot_s), .vtot(vtot_s), .hcount(hcount),
        .vcount(vcount), .line_end(line_end), .frame_end(frame_end)
    );

    rtg_syncwin #(.CW(CW), .LW(SYNCW)) hwin_i (
        .pos(hcount), .start(hss_s), .len_m1(hsw_s), .hit(h_hit)
    );

    rtg_syncwin #(.CW(CW), .LW(SYNCW)) vwin_i (
        .pos(vcount), .start(vss_s), .len_m1(vsw_s), .hit(v_hit)
    );

    rtg_l0addr #(.AW(AW), .CW(CW), .STRW(STRW)) addr_i (
        .clk(clk), .rst_n(rst_n), .run(run), .en_live(en_live),
        .line_end(line_end), .frame_end(frame_end), .vcount(vcount),
        .vdisp(vdisp_s), .stride(stride_s), .base_live(base_live),
        .addr(l0_addr)
    );

    // Purpose: decode the active-area and sync outputs from the position.
    always_comb begin
        de       = run && (hcount <= hdisp_s) && (vcount <= vdisp_s);
        hsync_n  = !(run && h_hit);
        vsync_n  = !(run && v_hit);
        l0_fetch = de && l0en_s;
    end

endmodule

// File: rtl/rtg_checker.sv
// Module: rtg_checker
// Property checks for raster_timing_gen. It is bound into every instance
// of the top and observes the ports together with the run flag, the live
// enable and the shadows.
module rtg_checker #(
    parameter int CW = 12,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          en_live,
    input logic          pix_en,
    input logic [CW-1:0] hcount,
    input logic [CW-1:0] vcount,
    input logic [CW-1:0] htot_s,
    input logic [CW-1:0] vtot_s,
    input logic          de,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic [AW-1:0] l0_addr,
    input logic [AW-1:0] base_s
);
    // R7: when not running, the raster is parked and the outputs are idle.
    p_idle_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (hcount == '0 && vcount == '0 && !de && hsync_n && vsync_n && !pix_en));

    // R2: without a pixel strobe, the position holds.
    p_hold_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en_live && !pix_en) |=> ($stable(hcount) && $stable(vcount)));

    // R3: the horizontal count wraps at its total.
    p_hwrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en_live && pix_en && hcount == htot_s) |=> (hcount == '0));

    // R3: the horizontal count steps by one below its total.
    p_hstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en_live && pix_en && hcount != htot_s) |=> (hcount == $past(hcount) + CW'(1)));

    // R3: the vertical count steps on each horizontal wrap below its total.
    p_vstep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && en_live && pix_en && hcount == htot_s && vcount != vtot_s)
        |=> (vcount == $past(vcount) + CW'(1)));

    // R9: the first pixel of a frame sees the base address.
    p_addr_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hcount == '0 && vcount == '0) |-> (l0_addr == base_s));

endmodule

bind raster_timing_gen rtg_checker #(.CW(CW), .AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .run(run), .en_live(en_live), .pix_en(pix_en),
    .hcount(hcount), .vcount(vcount), .htot_s(htot_s), .vtot_s(vtot_s),
    .de(de), .hsync_n(hsync_n), .vsync_n(vsync_n), .l0_addr(l0_addr),
    .base_s(base_s)
);

// File: tb/raster_timing_gen_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench. The driver task models each clock edge from the
// requirements and queues the expected port values. The monitor pops
// each entry and compares it against the design's outputs.
module raster_timing_gen_tb_top;
    localparam int CW = 12;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          pix_en, hsync_n, vsync_n, de, l0_fetch, l0_wide;
    logic [CW-1:0] hcount, vcount;
    logic [AW-1:0] l0_addr;

    raster_timing_gen #(.CW(CW), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .pix_en(pix_en), .hcount(hcount),
        .vcount(vcount), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
        .l0_fetch(l0_fetch), .l0_wide(l0_wide), .l0_addr(l0_addr)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int htot, hdisp, hss, hsw, vtot, vdisp, vss, vsw;
        int div, en, l0en, wide, stride;
        logic [31:0] base;
    } cfg_t;

    typedef struct packed {
        logic          pe;
        logic [CW-1:0] hc;
        logic [CW-1:0] vc;
        logic          de;
        logic          hs;
        logic          vs;
        logic          fetch;
        logic          wide;
        logic [31:0]   addr;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    total = 0;
    int    fails = 0;
    bit    finished = 0;

    cfg_t live_c, cur_c;
    int   run_m = 0, h_m = 0, v_m = 0, d_m = 0;

    task automatic check(input string req, input string ph, input string nm,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s phase %s %s: actual=%0h expected=%0h", req, ph, nm, act, exp);
        end
    endtask

    function automatic exp_t expect_now();
        exp_t e;
        int mn;
        e.pe    = (run_m != 0) && (d_m == cur_c.div);
        e.hc    = CW'(h_m);
        e.vc    = CW'(v_m);
        e.de    = (run_m != 0) && (h_m <= cur_c.hdisp) && (v_m <= cur_c.vdisp);
        e.hs    = !((run_m != 0) && (h_m >= cur_c.hss) && (h_m <= cur_c.hss + cur_c.hsw));
        e.vs    = !((run_m != 0) && (v_m >= cur_c.vss) && (v_m <= cur_c.vss + cur_c.vsw));
        e.fetch = e.de && (cur_c.l0en != 0);
        e.wide  = (cur_c.wide != 0);
        mn      = (v_m < cur_c.vdisp + 1) ? v_m : cur_c.vdisp + 1;
        e.addr  = cur_c.base + 32'(mn * cur_c.stride * 64);
        return e;
    endfunction

    // Decode a word into the live model, using the field positions of R3-R10.
    function automatic void apply_write(input logic [2:0] sel, input logic [31:0] d);
        case (sel)
            3'd0: live_c.htot = int'(d[27:16]);
            3'd1: live_c.hdisp = int'(d[11:0]);
            3'd2: begin live_c.vsw = int'(d[31:24]); live_c.hsw = int'(d[23:16]); live_c.hss = int'(d[11:0]); end
            3'd3: live_c.vtot = int'(d[27:16]);
            3'd4: begin live_c.vdisp = int'(d[27:16]); live_c.vss = int'(d[11:0]); end
            3'd5: begin live_c.en = int'(d[31]); live_c.l0en = int'(d[16]); live_c.div = int'(d[11:8]); end
            3'd6: begin live_c.wide = int'(d[31]); live_c.stride = int'(d[30:16]); end
            default: live_c.base = d;
        endcase
    endfunction

    // One model clock edge from the requirements (R2, R3, R7, R8).
    function automatic void model_edge(input logic we, input logic [2:0] sel, input logic [31:0] d);
        int wrap = 0;
        if (live_c.en == 0) begin
            h_m = 0; v_m = 0; d_m = 0;
        end else if (run_m != 0) begin
            if (d_m == cur_c.div) begin
                d_m = 0;
                if (h_m == cur_c.htot) begin
                    h_m = 0;
                    if (v_m == cur_c.vtot) begin v_m = 0; wrap = 1; end
                    else v_m = v_m + 1;
                end else h_m = h_m + 1;
            end else d_m = d_m + 1;
        end
        if (run_m == 0 || live_c.en == 0 || wrap != 0) cur_c = live_c;
        run_m = live_c.en;
        if (we) apply_write(sel, d);
    endfunction

    task automatic tick(input logic we, input logic [2:0] sel, input logic [31:0] d, input string ph);
        @(negedge clk);
        expq.push_back(expect_now());
        tagq.push_back(ph);
        cfg_we = we; cfg_sel = sel; cfg_wdata = d;
        model_edge(we, sel, d);
    endtask

    task automatic idle(input int n, input string ph);
        for (int i = 0; i < n; i++) tick(1'b0, 3'd0, 32'd0, ph);
    endtask

    // Monitor: compare each queued expectation away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (expq.size() > 0) begin
                exp_t  e;
                string ph;
                e  = expq.pop_front();
                ph = tagq.pop_front();
                check("R2", ph, "pix_en", 32'(pix_en), 32'(e.pe));
                check("R3", ph, "hcount", 32'(hcount), 32'(e.hc));
                check("R3", ph, "vcount", 32'(vcount), 32'(e.vc));
                check("R4", ph, "de", 32'(de), 32'(e.de));
                check("R5", ph, "hsync_n", 32'(hsync_n), 32'(e.hs));
                check("R6", ph, "vsync_n", 32'(vsync_n), 32'(e.vs));
                check("R9", ph, "l0_addr", l0_addr, e.addr);
                check("R10", ph, "l0_fetch", 32'(l0_fetch), 32'(e.fetch));
                check("R10", ph, "l0_wide", 32'(l0_wide), 32'(e.wide));
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // Driver: configure, run and reconfigure the block.
    initial begin
        live_c = '{default: 0};
        cur_c  = '{default: 0};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(5, "R1");
        // Small raster: 20x12 total, 12x8 active, one clock per pixel.
        tick(1, 3'd0, 32'h0013_0000, "R1");
        tick(1, 3'd1, 32'h000B_000B, "R1");
        tick(1, 3'd2, 32'h0102_000D, "R1");
        tick(1, 3'd3, 32'h000B_0000, "R1");
        tick(1, 3'd4, 32'h0007_0008, "R1");
        tick(1, 3'd6, 32'h8003_0000, "R1");
        tick(1, 3'd7, 32'h0000_1000, "R1");
        tick(1, 3'd5, 32'h8001_0000, "R7");
        idle(520, "R3");
        // Mid-frame divider change: three clocks per pixel from next frame.
        tick(1, 3'd5, 32'h8001_0200, "R8");
        idle(1500, "R8");
        // Mid-frame geometry and base change.
        idle(100, "R8");
        tick(1, 3'd0, 32'h0017_0000, "R8");
        tick(1, 3'd2, 32'h0200_000F, "R8");
        tick(1, 3'd7, 32'h0000_2000, "R8");
        idle(2000, "R8");
        // Layer 0 off, new stride, two clocks per pixel.
        tick(1, 3'd5, 32'h8000_0100, "R10");
        tick(1, 3'd6, 32'h0005_0000, "R10");
        idle(1300, "R10");
        // Display off, then a write while off, then on at four clocks per pixel.
        tick(1, 3'd5, 32'h0000_0100, "R7");
        idle(40, "R7");
        tick(1, 3'd4, 32'h0006_0009, "R7");
        idle(5, "R7");
        tick(1, 3'd5, 32'h8001_0300, "R2");
        idle(2500, "R2");
        @(negedge clk);
        #2;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule